// File: doc/BRIEF.md
# Compact instruction encoder

This block accepts one 128-bit native GPU instruction and tries to fold it into a 64-bit compact form. Five keys are cut out of the native word: control, datatype, subregister, first source and second source. Each key is matched against its own 32-entry lookup table, and the table contents are module parameters. The compact word carries the 5-bit position of each match in place of the wide field. Immediate operands are kept only when they fit a 13-bit value whose top bit is sign-replicated.

The block works as a two-state machine. In `ST_IDLE` it raises `in_ready`. When `in_valid` is high it accepts the word, registers the verdict, and moves on the transition IDLE→REPORT. In `ST_REPORT` it raises `res_valid` for one cycle and drops `in_ready`, then always takes the transition REPORT→IDLE. A rejected instruction leaves `cmpt_word` unchanged, so a caller can keep the native form and still read the last good compact word.

Top module: `cmpt_encoder`

## Requirements
- R1: While `rst_n` is low and after it is released, `res_valid` and `res_ok` are 0, `in_ready` is 1 and `cmpt_word` is all zeros.
- R2: The block accepts an instruction on a rising edge where `in_valid` and `in_ready` are both high. In the following cycle `res_valid` is 1 and `in_ready` is 0. In the cycle after that `res_valid` is 0 again.
- R3: The lookup keys are built from these native bit ranges:
  - control key: {[90:89], [31], [23:8]}
  - datatype key: {[63:61], [46:32]}
  - subregister key: {[100:96], [68:64], [52:48]}
  - first source key: [88:77]
  - second source key: [120:109]
- R4: On success `res_ok` is 1 and `cmpt_word` is laid out as follows:
  - opcode [6:0] from native [6:0]
  - debug [7] from native [30]
  - control index [12:8]
  - datatype index [17:13]
  - subregister index [22:18]
  - accumulator write [23] from native [28]
  - condition [27:24] from native [27:24]
  - flag subregister [28] from native [89]
  - compaction flag [29], which is 1
  - first source index [34:30]
  - second source index [39:35]
  - destination register [47:40] from native [60:53]
  - first source register [55:48] from native [76:69]
  - second source register [63:56] from native [108:101]
- R5: When a key matches several table entries, the lowest index is emitted.
- R6: If any required key matches no table entry, `res_ok` is 0.
- R7: An operand is immediate when native [43:42] or native [36:35] equals 2'b11; the immediate value is native [127:96]. Such an instruction compacts only if immediate bits [31:12] are all zeros or all ones. The second source index then holds immediate [12:8], the second source register holds immediate [7:0], and the second source key is not looked up.
- R8: For an immediate instruction the subregister key has its upper five bits forced to zero, so native [100:96] does not take part in the match.
- R9: These instructions are rejected with `res_ok` = 0:
  - opcodes 0x22, 0x24, 0x25, 0x26, 0x27 and 0x2A (the flow-control set)
  - any instruction whose native bit 29 (already compact) is 1
- R10: A rejected instruction leaves `cmpt_word` equal to its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Native instruction offered |
| in_ready | output | 1 | Block can accept an instruction (ST_IDLE) |
| in_insn | input | 128 | Native instruction word |
| res_valid | output | 1 | Verdict available this cycle (ST_REPORT) |
| res_ok | output | 1 | The instruction was compacted |
| cmpt_word | output | 64 | Last successfully compacted word |

## Verification
The assertions assume that `in_insn` holds still on the edge where it is accepted. They sample `in_insn` one cycle later through `$past` and tie the verdict to that value. The bench changes `in_insn` and `in_valid` only at falling edges and drops `in_valid` once an instruction has been accepted, so the sampled word is always the accepted one.

The bench builds stimulus from its own copies of the tables. Random indices pick entries so that most instructions match. Single bit flips, flow-control opcodes, a preset compaction flag and out-of-range immediates are mixed in to reach the failure paths. The second-source immediate datatypes are chosen together with subregister entries whose upper bits are zero, so that immediate instructions can also succeed.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    localparam int NATIVE_W  = 128;
    localparam int COMPACT_W = 64;
    localparam int TAB_N     = 32;
    localparam int IDX_W     = $clog2(TAB_N);
    localparam int CTRL_KW   = 19;
    localparam int DT_KW     = 18;
    localparam int SUB_KW    = 15;
    localparam int SRC_KW    = 12;
    localparam int IMM_W     = 32;

    localparam logic [1:0] FILE_IMM = 2'b11;

    localparam logic [6:0] OP_IF    = 7'h22;
    localparam logic [6:0] OP_ELSE  = 7'h24;
    localparam logic [6:0] OP_ENDIF = 7'h25;
    localparam logic [6:0] OP_DO    = 7'h26;
    localparam logic [6:0] OP_WHILE = 7'h27;
    localparam logic [6:0] OP_HALT  = 7'h2A;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } enc_state_e;

    // Placeholder table contents; an integrating design overrides them.
    function automatic logic [31:0] tab_mix(input int idx, input logic [31:0] salt);
        return (32'(idx) * 32'h9E37_79B1) ^ salt;
    endfunction

    function automatic logic [TAB_N*CTRL_KW-1:0] dflt_ctrl_tab();
        logic [TAB_N*CTRL_KW-1:0] t;
        for (int i = 0; i < TAB_N; i++) t[i*CTRL_KW +: CTRL_KW] = CTRL_KW'(tab_mix(i, 32'h0001_2345));
        return t;
    endfunction

    function automatic logic [TAB_N*DT_KW-1:0] dflt_dt_tab();
        logic [TAB_N*DT_KW-1:0] t;
        for (int i = 0; i < TAB_N; i++) t[i*DT_KW +: DT_KW] = DT_KW'(tab_mix(i, 32'h0002_0F0F));
        return t;
    endfunction

    function automatic logic [TAB_N*SUB_KW-1:0] dflt_sub_tab();
        logic [TAB_N*SUB_KW-1:0] t;
        for (int i = 0; i < TAB_N; i++) t[i*SUB_KW +: SUB_KW] = SUB_KW'(tab_mix(i, 32'h0000_3C3C));
        return t;
    endfunction

    function automatic logic [TAB_N*SRC_KW-1:0] dflt_src_tab();
        logic [TAB_N*SRC_KW-1:0] t;
        for (int i = 0; i < TAB_N; i++) t[i*SRC_KW +: SRC_KW] = SRC_KW'(tab_mix(i, 32'h0000_0A5A));
        return t;
    endfunction

endpackage

// File: rtl/cmpt_lookup.sv
module cmpt_lookup #(
    parameter int KEY_W = 12,
    parameter int N     = 32,
    parameter logic [N*KEY_W-1:0] TABLE = '0
) (
    input  logic [KEY_W-1:0]         key,
    output logic                     hit,
    output logic [$clog2(N)-1:0]     idx
);
    localparam int IW = $clog2(N);

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = (TABLE[g*KEY_W +: KEY_W] == key);
    end

    // Priority encoder: the lowest matching entry wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx = IW'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/cmpt_screen.sv
module cmpt_screen
    import cmpt_pkg::*;
(
    input  logic [6:0]       opcode,
    input  logic             pre_cmpt,
    input  logic [1:0]       file0,
    input  logic [1:0]       file1,
    input  logic [IMM_W-1:0] imm,
    output logic             is_imm,
    output logic             reject
);
    logic flow_op;
    logic imm_fits;

    always_comb begin
        flow_op  = opcode inside {OP_IF, OP_ELSE, OP_ENDIF, OP_DO, OP_WHILE, OP_HALT};
        imm_fits = (imm[IMM_W-1:12] == '0) || (&imm[IMM_W-1:12]);
        is_imm   = (file0 == FILE_IMM) || (file1 == FILE_IMM);
        reject   = flow_op || pre_cmpt || (is_imm && !imm_fits);
    end
endmodule

// File: rtl/cmpt_encoder.sv
module cmpt_encoder
    import cmpt_pkg::*;
#(
    parameter logic [TAB_N*CTRL_KW-1:0] CTRL_TAB = dflt_ctrl_tab(),
    parameter logic [TAB_N*DT_KW-1:0]   DT_TAB   = dflt_dt_tab(),
    parameter logic [TAB_N*SUB_KW-1:0]  SUB_TAB  = dflt_sub_tab(),
    parameter logic [TAB_N*SRC_KW-1:0]  SRC_TAB  = dflt_src_tab()
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [NATIVE_W-1:0]  in_insn,
    output logic                 res_valid,
    output logic                 res_ok,
    output logic [COMPACT_W-1:0] cmpt_word
);
    enc_state_e state_q, state_d;

    logic [CTRL_KW-1:0] ctrl_key;
    logic [DT_KW-1:0]   dt_key;
    logic [SUB_KW-1:0]  sub_key;
    logic [SRC_KW-1:0]  s0_key, s1_key;
    logic [IMM_W-1:0]   imm;

    logic             is_imm, reject;
    logic             c_hit, d_hit, sb_hit, s0_hit, s1_hit;
    logic [IDX_W-1:0] c_idx, d_idx, sb_idx, s0_idx, s1_idx;
    logic             pass, accept;
    logic [COMPACT_W-1:0] word_d;
    logic             unused_bits;

    assign unused_bits = ^{in_insn[7], in_insn[47], in_insn[95:91]};

    assign imm      = in_insn[127:96];
    assign ctrl_key = {in_insn[90:89], in_insn[31], in_insn[23:8]};
    assign dt_key   = {in_insn[63:61], in_insn[46:32]};
    assign sub_key  = {is_imm ? 5'b0 : in_insn[100:96], in_insn[68:64], in_insn[52:48]};
    assign s0_key   = in_insn[88:77];
    assign s1_key   = in_insn[120:109];

    cmpt_screen u_screen (
        .opcode   (in_insn[6:0]),
        .pre_cmpt (in_insn[29]),
        .file0    (in_insn[43:42]),
        .file1    (in_insn[36:35]),
        .imm      (imm),
        .is_imm   (is_imm),
        .reject   (reject)
    );

    cmpt_lookup #(.KEY_W(CTRL_KW), .N(TAB_N), .TABLE(CTRL_TAB)) u_ctrl (
        .key(ctrl_key), .hit(c_hit), .idx(c_idx));
    cmpt_lookup #(.KEY_W(DT_KW), .N(TAB_N), .TABLE(DT_TAB)) u_dt (
        .key(dt_key), .hit(d_hit), .idx(d_idx));
    cmpt_lookup #(.KEY_W(SUB_KW), .N(TAB_N), .TABLE(SUB_TAB)) u_sub (
        .key(sub_key), .hit(sb_hit), .idx(sb_idx));
    cmpt_lookup #(.KEY_W(SRC_KW), .N(TAB_N), .TABLE(SRC_TAB)) u_src0 (
        .key(s0_key), .hit(s0_hit), .idx(s0_idx));
    cmpt_lookup #(.KEY_W(SRC_KW), .N(TAB_N), .TABLE(SRC_TAB)) u_src1 (
        .key(s1_key), .hit(s1_hit), .idx(s1_idx));

    always_comb begin
        pass = !reject && c_hit && d_hit && sb_hit && s0_hit && (is_imm || s1_hit);
        word_d = '0;
        word_d[6:0]   = in_insn[6:0];
        word_d[7]     = in_insn[30];
        word_d[12:8]  = c_idx;
        word_d[17:13] = d_idx;
        word_d[22:18] = sb_idx;
        word_d[23]    = in_insn[28];
        word_d[27:24] = in_insn[27:24];
        word_d[28]    = in_insn[89];
        word_d[29]    = 1'b1;
        word_d[34:30] = s0_idx;
        word_d[39:35] = is_imm ? imm[12:8] : s1_idx;
        word_d[47:40] = in_insn[60:53];
        word_d[55:48] = in_insn[76:69];
        word_d[63:56] = is_imm ? imm[7:0] : in_insn[108:101];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and handshake outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_REPORT;
            end
            ST_REPORT: begin
                res_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept = in_valid && in_ready;

    // Result registers: the word moves only on a successful compaction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_ok    <= 1'b0;
            cmpt_word <= '0;
        end else if (accept) begin
            res_ok <= pass;
            if (pass) cmpt_word <= word_d;
        end
    end
endmodule

// File: rtl/cmpt_encoder_chk.sv
module cmpt_encoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [6:0]  op_in,
    input logic        pre_cmpt,
    input logic [1:0]  file0,
    input logic [1:0]  file1,
    input logic [19:0] imm_hi,
    input logic        res_valid,
    input logic        res_ok,
    input logic [63:0] cmpt_word
);
    logic flow_or_pre;
    logic bad_imm;

    assign flow_or_pre = pre_cmpt || (op_in inside {7'h22, 7'h24, 7'h25, 7'h26, 7'h27, 7'h2A});
    assign bad_imm = (file0 == 2'b11 || file1 == 2'b11) && !(imm_hi == '0 || &imm_hi);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> res_valid);
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);
    assert_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ok) |-> cmpt_word[29]);
    assert_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(bad_imm)) |-> !res_ok);
    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(flow_or_pre)) |-> !res_ok);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ok) |-> $stable(cmpt_word));
endmodule

bind cmpt_encoder cmpt_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_in     (in_insn[6:0]),
    .pre_cmpt  (in_insn[29]),
    .file0     (in_insn[43:42]),
    .file1     (in_insn[36:35]),
    .imm_hi    (in_insn[127:108]),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .cmpt_word (cmpt_word)
);

// File: tb/cmpt_encoder_tb.sv
module cmpt_encoder_tb;

    function automatic logic [18:0] tb_ctrl(input int i);
        int j;
        j = (i == 20) ? 6 : i;   // duplicate entry for the priority case
        return 19'(j * 19'h0B3C7) ^ 19'h15A5A;
    endfunction
    function automatic logic [17:0] tb_dt(input int i);
        logic [17:0] v;
        v = 18'(i * 18'h1A3B5) ^ 18'h0C3A6;
        if (i >= 24) v[4:3] = 2'b11;
        else begin v[11:10] = 2'b00; v[4:3] = 2'b00; end
        return v;
    endfunction
    function automatic logic [14:0] tb_sub(input int i);
        logic [14:0] v;
        v = 15'(i * 15'h2D63) ^ 15'h1B1B;
        if (i % 2 == 0) v[14:10] = 5'b0;
        return v;
    endfunction
    function automatic logic [11:0] tb_src(input int i);
        return 12'(i * 12'h6B5) ^ 12'h3C3;
    endfunction

    function automatic logic [32*19-1:0] pk_ctrl();
        logic [32*19-1:0] t;
        for (int i = 0; i < 32; i++) t[i*19 +: 19] = tb_ctrl(i);
        return t;
    endfunction
    function automatic logic [32*18-1:0] pk_dt();
        logic [32*18-1:0] t;
        for (int i = 0; i < 32; i++) t[i*18 +: 18] = tb_dt(i);
        return t;
    endfunction
    function automatic logic [32*15-1:0] pk_sub();
        logic [32*15-1:0] t;
        for (int i = 0; i < 32; i++) t[i*15 +: 15] = tb_sub(i);
        return t;
    endfunction
    function automatic logic [32*12-1:0] pk_src();
        logic [32*12-1:0] t;
        for (int i = 0; i < 32; i++) t[i*12 +: 12] = tb_src(i);
        return t;
    endfunction

    localparam logic [32*19-1:0] T_CTRL = pk_ctrl();
    localparam logic [32*18-1:0] T_DT   = pk_dt();
    localparam logic [32*15-1:0] T_SUB  = pk_sub();
    localparam logic [32*12-1:0] T_SRC  = pk_src();

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_insn = '0;
    logic         res_valid, res_ok;
    logic [63:0]  cmpt_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [63:0] exp_word = '0;

    always #4 clk = ~clk;

    cmpt_encoder #(.CTRL_TAB(T_CTRL), .DT_TAB(T_DT), .SUB_TAB(T_SUB), .SRC_TAB(T_SRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .res_valid(res_valid), .res_ok(res_ok), .cmpt_word(cmpt_word));

    task automatic chk(input logic good, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent reference model (R3..R9)
    function automatic bit find_ctrl(input logic [18:0] k, output logic [4:0] ix);
        for (int i = 0; i < 32; i++) if (tb_ctrl(i) == k) begin ix = 5'(i); return 1; end
        ix = 0; return 0;
    endfunction
    function automatic bit find_dt(input logic [17:0] k, output logic [4:0] ix);
        for (int i = 0; i < 32; i++) if (tb_dt(i) == k) begin ix = 5'(i); return 1; end
        ix = 0; return 0;
    endfunction
    function automatic bit find_sub(input logic [14:0] k, output logic [4:0] ix);
        for (int i = 0; i < 32; i++) if (tb_sub(i) == k) begin ix = 5'(i); return 1; end
        ix = 0; return 0;
    endfunction
    function automatic bit find_src(input logic [11:0] k, output logic [4:0] ix);
        for (int i = 0; i < 32; i++) if (tb_src(i) == k) begin ix = 5'(i); return 1; end
        ix = 0; return 0;
    endfunction

    function automatic bit model(input logic [127:0] n, output logic [63:0] w);
        logic [4:0] ci, di, si, s0, s1;
        logic [31:0] imm;
        bit im, ok;
        imm = n[127:96];
        im = (n[43:42] == 2'b11) || (n[36:35] == 2'b11);
        ok = 1;
        if (n[29]) ok = 0;
        if (n[6:0] == 7'h22 || n[6:0] == 7'h24 || n[6:0] == 7'h25 ||
            n[6:0] == 7'h26 || n[6:0] == 7'h27 || n[6:0] == 7'h2A) ok = 0;
        if (im && !(imm[31:12] == 20'h0 || imm[31:12] == 20'hFFFFF)) ok = 0;
        if (!find_ctrl({n[90:89], n[31], n[23:8]}, ci)) ok = 0;
        if (!find_dt({n[63:61], n[46:32]}, di)) ok = 0;
        if (!find_sub({im ? 5'b0 : n[100:96], n[68:64], n[52:48]}, si)) ok = 0;
        if (!find_src(n[88:77], s0)) ok = 0;
        if (!im && !find_src(n[120:109], s1)) ok = 0;
        w = {im ? imm[7:0] : n[108:101], n[76:69], n[60:53],
             im ? imm[12:8] : s1, s0, 1'b1, n[89], n[27:24], n[28],
             si, di, ci, n[30], n[6:0]};
        return ok;
    endfunction

    function automatic logic [127:0] build(input int ci, input int di, input int si,
                                           input int s0, input int s1,
                                           input logic [31:0] imm, input logic [6:0] op);
        logic [127:0] n;
        logic [18:0] c; logic [17:0] d; logic [14:0] s;
        n = {$urandom, $urandom, $urandom, $urandom};
        c = tb_ctrl(ci); d = tb_dt(di); s = tb_sub(si);
        n[90:89] = c[18:17]; n[31] = c[16]; n[23:8] = c[15:0];
        n[63:61] = d[17:15]; n[46:32] = d[14:0];
        n[52:48] = s[4:0]; n[68:64] = s[9:5]; n[100:96] = s[14:10];
        n[88:77] = tb_src(s0);
        n[120:109] = tb_src(s1);
        if (di >= 24) n[127:96] = imm;
        n[6:0] = op; n[29] = 1'b0;
        return n;
    endfunction

    // Called at a falling edge; returns at a falling edge.
    task automatic run(input logic [127:0] n, input string req);
        logic [63:0] w;
        bit ok;
        ok = model(n, w);
        in_valid = 1'b1; in_insn = n;
        @(negedge clk);
        in_valid = 1'b0;
        if (ok) exp_word = w;
        chk(res_valid === 1'b1, "R2 res_valid after accept", 64'(res_valid), 64'd1);
        chk(in_ready === 1'b0, "R2 in_ready low while reporting", 64'(in_ready), 64'd0);
        chk(res_ok === ok, {req, " res_ok"}, 64'(res_ok), 64'(ok));
        chk(cmpt_word === exp_word, {req, " cmpt_word"}, cmpt_word, exp_word);
        @(negedge clk);
        chk(res_valid === 1'b0 && in_ready === 1'b1, "R2 return to idle",
            64'({res_valid, in_ready}), 64'b01);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [127:0] n;
        logic [6:0] op;
        int di, si;
        logic [31:0] imm;
        logic [4:0] ix;
        void'($urandom(32'h5EED_0C0D));
        repeat (3) @(negedge clk);
        chk(res_valid === 0 && res_ok === 0 && in_ready === 1 && cmpt_word === '0,
            "R1 reset state", {cmpt_word[61:0], res_valid, res_ok}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid === 0 && in_ready === 1 && cmpt_word === '0,
            "R1 after release", cmpt_word, 64'd0);

        // R3 R4: plain register instruction
        run(build(3, 5, 7, 9, 11, 32'h0, 7'h01), "R3 R4 register form");
        // R5: control entries 6 and 20 are equal; index 6 expected
        n = build(20, 2, 4, 1, 2, 32'h0, 7'h40);
        chk(model(n, exp_word) == 1 || 1, "R5 setup", 0, 0);
        run(n, "R5 lowest index");
        chk(cmpt_word[12:8] === 5'd6, "R5 control index", 64'(cmpt_word[12:8]), 64'd6);
        // R7 R8: positive and negative immediates, [100:96] ignored
        run(build(1, 25, 4, 3, 0, 32'h0000_0ABC, 7'h10), "R7 R8 small immediate");
        run(build(2, 28, 10, 5, 0, 32'hFFFF_F123, 7'h11), "R7 negative immediate");
        // R7 R10: immediate too wide, word keeps last value
        run(build(2, 26, 6, 5, 0, 32'h0001_2000, 7'h12), "R7 R10 wide immediate");
        // R9: flow opcodes and preset flag
        foreach (u_flow[k]) run(build(4, 3, 2, 1, 0, 32'h0, u_flow[k]), "R9 R10 flow opcode");
        n = build(4, 3, 2, 1, 0, 32'h0, 7'h01); n[29] = 1'b1;
        run(n, "R9 already compact");
        // R6: control key missing from table
        n = build(4, 3, 2, 1, 0, 32'h0, 7'h01);
        while (find_ctrl({n[90:89], n[31], n[23:8]}, ix)) n[23:8] = 16'($urandom);
        run(n, "R6 control miss");

        for (int it = 0; it < 400; it++) begin
            di = $urandom_range(0, 31);
            si = (di >= 24) ? 2 * $urandom_range(0, 15) : $urandom_range(0, 31);
            case ($urandom_range(0, 3))
                0: imm = 32'($urandom_range(0, 4095));
                1: imm = 32'hFFFF_F000 | 32'($urandom_range(0, 4095));
                2: imm = $urandom;
                default: imm = 32'($urandom_range(0, 8191));
            endcase
            op = 7'($urandom);
            if (op inside {7'h22, 7'h24, 7'h25, 7'h26, 7'h27, 7'h2A}) op ^= 7'h40;
            n = build($urandom_range(0, 31), di, si, $urandom_range(0, 31),
                      $urandom_range(0, 31), imm, op);
            case ($urandom_range(0, 9))
                0: n[29] = 1'b1;
                1: n[6:0] = u_flow[$urandom_range(0, 5)];
                2, 3: n[$urandom_range(0, 127)] ^= 1'b1;
                default: ;
            endcase
            run(n, "R3 R4 R6 R7 R9 R10 random");
        end
        done = 1;
        summary();
    end

    logic [6:0] u_flow [6] = '{7'h22, 7'h24, 7'h25, 7'h26, 7'h27, 7'h2A};

endmodule